// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits behind an 8-bit host I/O port that covers 64 byte offsets. The lowest eight offsets always reach a group of system registers. These hold a general configuration byte, a 3-bit window-select field, a 15-bit local memory address and a 32-bit data port. The offsets above the system group reach a 32-entry internal register file. Depending on the window-select value, that file is shown either as one of four pages of eight bytes or as a single flat 32-byte run. Offsets that fall outside the chosen layout are undefined.

The address and data-port registers give the host indirect access to external local memory through a simple synchronous request interface. The memory returns read data one cycle after a read request. A host read issues in the cycle that `host_rd` is high, and its byte appears on `host_rdata` in the following cycle.

Top module: `bank_window_decoder`

## Requirements
- R1: After reset every register is zero, so the window select is 000 (paged, page 0), reads of any offset return 00h, and no memory request is issued while idle.
- R2: Offsets 00h–07h reach the system registers for every window-select value. Offset 00h is a full 8-bit read/write configuration byte.
- R3: The window select is bits [2:0] of offset 01h. Bits [7:3] of offset 01h read as 0.
- R4: When select bit 2 is 0, offset 08h+k (k = 0..7) reaches internal register 8·S+k, where S is select bits [1:0].
- R5: When select bit 2 is 0, offsets 10h–3Fh read as 00h, and writes to them change no register.
- R6: When select bit 2 is 1, offset 08h+n (n = 0..31) reaches internal register n.
- R7: When select bit 2 is 1, offsets 28h–3Fh read as 00h, and writes to them change no register.
- R8: The local memory address is {offset 03h bits [6:0], offset 02h}, and it is presented on `mem_addr`. Bit 7 of offset 03h reads as 0.
- R9: Offsets 04h–07h hold data bytes 0 (least significant) to 3. A host write to 07h issues exactly one memory write of {07h, 06h, 05h, 04h} at the local address. Writes to 04h–06h issue no request.
- R10: A host read of 04h issues one memory read. That read returns memory byte 0 and latches all four bytes, so later reads of 05h–07h return bytes 1–3.
- R11: A new window-select value governs the host access in the cycle right after the write that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 6 | Host byte offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after host_rd |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Local memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
The assertions assume that the host never raises `host_rd` and `host_wr` in the same cycle, and one assertion checks this. They also assume that `mem_rdata` carries the requested word in the cycle after a read request. The bench drives at most one strobe per access and leaves an idle cycle between accesses. Its memory model answers every read request with the stored word on the next clock edge, so both assumptions hold throughout the run.

// File: rtl/bank_window_decoder.sv
module bank_window_decoder #(
  parameter int NREG = 32,
  parameter int PAGE = 8,
  parameter int MAW  = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [5:0]     host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata
);
  localparam int IW    = $clog2(NREG);
  localparam int PW    = $clog2(PAGE);
  localparam int HIW   = MAW - 8;
  localparam int FLAT_END = 8 + NREG;

  logic [7:0]     cfg_q, lo_q;
  logic [2:0]     sel_q;
  logic [HIW-1:0] hi_q;
  logic [7:0]     dp_q [4];
  logic [7:0]     rf_q [NREG];
  logic [7:0]     sys_byte, rd_byte, rd_byte_q;
  logic           rd_mem_q;

  wire flat    = sel_q[2];
  wire is_sys  = host_addr < 6'd8;
  wire in_page = !flat && (host_addr >= 6'd8) && (host_addr < 6'(8 + PAGE));
  wire in_flat = flat && (host_addr >= 6'd8) && (32'(host_addr) < FLAT_END);
  wire rf_hit  = in_page || in_flat;
  wire [IW-1:0] rf_idx = flat ? IW'(host_addr - 6'd8)
                              : IW'({sel_q[1:0], host_addr[PW-1:0]});

  always_comb begin
    case (host_addr[2:0])
      3'd0: sys_byte = cfg_q;
      3'd1: sys_byte = {5'd0, sel_q};
      3'd2: sys_byte = lo_q;
      3'd3: sys_byte = 8'(hi_q);
      default: sys_byte = dp_q[host_addr[1:0]];
    endcase
  end

  assign rd_byte = is_sys ? sys_byte : (rf_hit ? rf_q[rf_idx] : 8'h00);

  assign mem_req   = (host_wr && host_addr == 6'd7) || (host_rd && host_addr == 6'd4);
  assign mem_we    = host_wr;
  assign mem_addr  = {hi_q, lo_q};
  assign mem_wdata = {host_wdata, dp_q[2], dp_q[1], dp_q[0]};
  assign host_rdata = rd_mem_q ? mem_rdata[7:0] : rd_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      sel_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      rd_byte_q <= '0;
      rd_mem_q  <= 1'b0;
      for (int i = 0; i < 4; i++) dp_q[i] <= '0;
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else begin
      rd_mem_q <= host_rd && host_addr == 6'd4;
      if (host_rd) rd_byte_q <= rd_byte;
      if (rd_mem_q)
        for (int i = 0; i < 4; i++) dp_q[i] <= mem_rdata[8*i +: 8];
      if (host_wr) begin
        if (is_sys) begin
          case (host_addr[2:0])
            3'd0: cfg_q <= host_wdata;
            3'd1: sel_q <= host_wdata[2:0];
            3'd2: lo_q  <= host_wdata;
            3'd3: hi_q  <= host_wdata[HIW-1:0];
            default: dp_q[host_addr[1:0]] <= host_wdata;
          endcase
        end else if (rf_hit) begin
          rf_q[rf_idx] <= host_wdata;
        end
      end
    end
  end

  // input rule behind every check below
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_wr));

  // R3
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 6'd1 |=> host_rdata[7:3] == 5'd0);

  // R8
  addr_bit7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 6'd3 |=> host_rdata[7] == 1'b0);

  // R5
  paged_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !sel_q[2] && host_addr >= 6'h10 |=> host_rdata == 8'h00);

  // R7
  flat_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && sel_q[2] && host_addr >= 6'h28 |=> host_rdata == 8'h00);

  // R10
  mem_read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> host_rdata == mem_rdata[7:0]);

  // R9
  write_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |=> $stable(mem_addr));
endmodule

// File: tb/sim_bank_window_decoder.sv
`timescale 1ns/1ps
module sim_bank_window_decoder;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;

  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [31:0] mem_m [0:31];
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  bank_window_decoder u0 (.*);

  always @(posedge clk) begin
    rd_seen <= host_rd;
    if (mem_req && mem_we) begin mem_m[mem_addr[4:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_req && !mem_we) begin mem_rdata <= mem_m[mem_addr[4:0]]; rd_cnt <= rd_cnt + 1; end
  end

  always @(negedge clk) if (rd_seen && exp_q.size() > 0) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (host_rdata !== e) begin
      fails++;
      $display("FAIL %s: read got %02h expected %02h", t, host_rdata, e);
    end
  end

  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] e, string t);
    @(negedge clk); host_addr = a; host_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); host_rd = 0;
  endtask

  function automatic logic [7:0] val(int n);
    return 8'(n * 7 + 3);
  endfunction

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem_m[i] = 32'h0;
    mem_m[5] = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 mem_req idle", mem_req, 0);
    rd(6'h00, 8'h00, "R1");
    rd(6'h01, 8'h00, "R1");
    rd(6'h03, 8'h00, "R1");
    rd(6'h08, 8'h00, "R1");
    // R2 / R3
    wr(6'h00, 8'hA5);
    rd(6'h00, 8'hA5, "R2");
    wr(6'h01, 8'hFF);
    rd(6'h01, 8'h07, "R3");
    rd(6'h00, 8'hA5, "R2 flat select");
    // R6 flat fill
    for (int i = 0; i < 32; i++) wr(6'(8 + i), val(i));
    rd(6'h08, val(0), "R6");
    rd(6'h27, val(31), "R6");
    rd(6'h18, val(16), "R6");
    // R7 holes in flat mode
    wr(6'h28, 8'hEE);
    wr(6'h3F, 8'h11);
    rd(6'h28, 8'h00, "R7");
    rd(6'h3F, 8'h00, "R7");
    // R11 then R4 pages
    wr(6'h01, 8'h02);
    rd(6'h08, val(16), "R11");
    for (int p = 0; p < 4; p++) begin
      wr(6'h01, 8'(p));
      for (int k = 0; k < 8; k++) rd(6'(8 + k), val(p * 8 + k), "R4");
    end
    // R5 holes in paged mode
    wr(6'h10, 8'h55);
    wr(6'h20, 8'h66);
    wr(6'h3F, 8'h77);
    rd(6'h10, 8'h00, "R5");
    rd(6'h27, 8'h00, "R5");
    wr(6'h01, 8'h04);
    for (int i = 0; i < 32; i++) rd(6'(8 + i), val(i), "R5/R7 no side effect");
    // R8 address
    wr(6'h02, 8'h34);
    wr(6'h03, 8'hFF);
    rd(6'h03, 8'h7F, "R8");
    rd(6'h02, 8'h34, "R8");
    @(negedge clk);
    chk("R8 mem_addr", mem_addr, 15'h7F34);
    // R9 memory write
    wr(6'h04, 8'h11);
    wr(6'h05, 8'h22);
    wr(6'h06, 8'h33);
    @(negedge clk);
    chk("R9 no write before top byte", wr_cnt, 0);
    wr(6'h07, 8'h44);
    @(negedge clk);
    chk("R9 one write", wr_cnt, 1);
    chk("R9 word", mem_m[5'h14], 32'h44332211);
    // R10 memory read
    wr(6'h02, 8'h05);
    wr(6'h03, 8'h00);
    rd(6'h04, 8'hEF, "R10");
    rd(6'h05, 8'hBE, "R10");
    rd(6'h06, 8'hAD, "R10");
    rd(6'h07, 8'hDE, "R10");
    @(negedge clk);
    chk("R10 one read", rd_cnt, 1);
    chk("R10 reads no write", wr_cnt, 1);
    done = 1;
    finish_run();
  end
endmodule